// File: doc/BRIEF.md
# EEPROM Array Command and Address Engine

This block sits behind a two-wire bus front end that has already turned bit traffic into byte events (start, stop, received byte, request for a byte to send). It decodes the control byte, collects a two-byte word address, gathers written data into a one-page staging buffer and keeps the internal address counter. It serves current-address, random and sequential reads straight out of a synthesizable byte array.

Data is written to the array only when the stop arrives. A self-timed write cycle then runs for a parameterised number of system clocks. While that cycle runs the block refuses its own control byte, so a host can poll for completion. A write-protect input turns the whole array read-only. Data bytes are still accepted in that state, but nothing is programmed.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: During reset and on the first cycle after it, `busy_o`, `ack_o` and `tx_byte_o` are all zero.
- R2: After a start, the first received byte is acknowledged only when its upper four bits are 1010, its bits 3..1 equal `dev_sel_i` and no write cycle is running. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. A refused control byte, and every byte after it up to the next start, is answered with `ack_o` = 0.
- R3: In a write, the two word-address bytes (high byte first) and every data byte are acknowledged. Address bits at and above ADDR_W are ignored.
- R4: Nothing is written to the array before a stop. A stop that ends a write carrying at least one data byte, with `wp_i` low, raises `busy_o` on the next clock edge. `busy_o` then stays high for exactly WR_CYCLES clocks.
- R5: While `busy_o` is high, a matching control byte gets `ack_o` = 0. Once `busy_o` has fallen, the same byte is acknowledged.
- R6: During a page write only the low PAGE_W address bits advance after each data byte. More than 2**PAGE_W bytes wrap and overwrite earlier bytes of the same page. Bytes in other pages, and bytes of a partial page that were not sent, keep their values.
- R7: A current-address read returns the byte at the last accessed address plus one. After a page write this increment wraps inside the page.
- R8: A random read returns the byte at the word address sent in a preceding dummy write, after a repeated start with a read control byte.
- R9: Each byte request in a read returns the next byte. The counter rolls from the last array location to location 0.
- R10: With `wp_i` high at the stop, data bytes are still acknowledged. `busy_o` stays low and the array keeps its contents.
- R11: A stop after the word address but before any data byte leaves the array unchanged and `busy_o` low, and it loads the address counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel_i | input | 3 | Hardware select value compared with control-byte bits 3..1 |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| start_i | input | 1 | One-cycle pulse: start or repeated start seen on the bus |
| stop_i | input | 1 | One-cycle pulse: stop seen on the bus |
| rx_valid_i | input | 1 | One-cycle pulse: a byte from the host is complete |
| rx_byte_i | input | 8 | Received byte, valid with `rx_valid_i` |
| ack_o | output | 1 | Acknowledge answer for the last received byte, updated one clock after `rx_valid_i` |
| tx_req_i | input | 1 | One-cycle pulse: the front end needs the next read byte |
| tx_byte_o | output | 8 | Read byte, updated one clock after `tx_req_i` |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
Byte writes are spread over pages at the array ends and the middle, and each is read back by random read. This separates correct address assembly from dropped or misplaced high bits, including an address whose bits above the array width are set. A 34-byte page write that starts two bytes before the page end, checked by a current-address read and a full sequential read, tells in-page wrap and overwrite apart from carries into the next page. A read that crosses the last location tells array-wide rollover apart from page wrap. Polling during the timed cycle, protected writes, stops with no data, and foreign control bytes each separate "accepted and ignored" from "refused" at the acknowledge and busy outputs.

// File: rtl/ee_pkg.sv
package ee_pkg;
   localparam logic [3:0] CTRL_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDATA,
      ST_READ
   } ee_state_e;
endpackage

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
   parameter int PAGE_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PAGE_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int SLOTS = 1 << PAGE_W;

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [SLOTS-1:0]  used_q;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
            used_q[s] <= 1'b0;
         end else if (clr) begin
            used_q[s] <= 1'b0;
         end else if (wr_en && (wr_idx == PAGE_W'(s))) begin
            slot_q[s] <= wr_data;
            used_q[s] <= 1'b1;
         end
      end
   end

   assign rd_data  = slot_q[rd_idx];
   assign rd_valid = used_q[rd_idx];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
   parameter int CYCLES = 64,
   parameter int CW     = $clog2(CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [CW-1:0] elapsed
);
   logic [CW-1:0] left_q;
   logic [CW-1:0] el_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         el_q   <= '0;
      end else if (start) begin
         left_q <= CW'(CYCLES);
         el_q   <= '0;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
         el_q   <= el_q + 1'b1;
      end
   end

   assign busy    = (left_q != '0);
   assign elapsed = el_q;
endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine #(
   parameter int ADDR_W    = 10,
   parameter int PAGE_W    = 5,
   parameter int WR_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] dev_sel_i,
   input  logic       wp_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_byte_i,
   output logic       ack_o,
   input  logic       tx_req_i,
   output logic [7:0] tx_byte_o,
   output logic       busy_o
);
   import ee_pkg::*;

   localparam int DATA_W = 8;
   localparam int HI_W   = ADDR_W - 8;
   localparam int PAGE_N = 1 << PAGE_W;
   localparam int CW     = $clog2(WR_CYCLES + 1);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 9..16 for a two-byte word address");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must be at least 1 and below ADDR_W");
   end
   if (WR_CYCLES < PAGE_N) begin : g_bad_cycles
      $error("WR_CYCLES must cover one commit clock per page byte");
   end

   ee_state_e                state_q;
   logic [HI_W-1:0]          hi_q;
   logic [ADDR_W-1:0]        addr_q;
   logic [ADDR_W-PAGE_W-1:0] base_q;
   logic                     got_data_q;
   logic                     ack_q;
   logic [DATA_W-1:0]        tx_q;

   logic                     dev_match;
   logic [ADDR_W-1:0]        load_addr;
   logic [ADDR_W-1:0]        page_next;
   logic                     commit_start;
   logic                     busy;
   logic [CW-1:0]            commit_idx;
   logic [DATA_W-1:0]        buf_data;
   logic                     buf_vld;
   logic                     buf_clr;
   logic                     buf_wr;
   logic                     mem_we;
   logic [ADDR_W-1:0]        mem_waddr;
   logic [DATA_W-1:0]        mem_rdata;
   logic                     dev_phase;

   assign dev_match = (rx_byte_i[7:4] == CTRL_CODE) && (rx_byte_i[3:1] == dev_sel_i);
   assign load_addr = {hi_q, rx_byte_i};
   assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
   assign commit_start = stop_i && (state_q == ST_WDATA) && got_data_q && !wp_i;
   assign buf_clr   = rx_valid_i && (state_q == ST_ALO);
   assign buf_wr    = rx_valid_i && (state_q == ST_WDATA);
   assign dev_phase = (state_q == ST_DEV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         hi_q       <= '0;
         addr_q     <= '0;
         base_q     <= '0;
         got_data_q <= 1'b0;
         ack_q      <= 1'b0;
         tx_q       <= '0;
      end else if (start_i) begin
         state_q    <= ST_DEV;
         got_data_q <= 1'b0;
      end else if (stop_i) begin
         state_q    <= ST_IDLE;
         got_data_q <= 1'b0;
      end else if (rx_valid_i) begin
         unique case (state_q)
            ST_DEV: begin
               if (dev_match && !busy) begin
                  ack_q   <= 1'b1;
                  state_q <= rx_byte_i[0] ? ST_READ : ST_AHI;
               end else begin
                  ack_q   <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            ST_AHI: begin
               ack_q   <= 1'b1;
               hi_q    <= rx_byte_i[HI_W-1:0];
               state_q <= ST_ALO;
            end
            ST_ALO: begin
               ack_q   <= 1'b1;
               addr_q  <= load_addr;
               base_q  <= load_addr[ADDR_W-1:PAGE_W];
               state_q <= ST_WDATA;
            end
            ST_WDATA: begin
               ack_q      <= 1'b1;
               addr_q     <= page_next;
               got_data_q <= 1'b1;
            end
            default: ack_q <= 1'b0;
         endcase
      end else if (tx_req_i && (state_q == ST_READ)) begin
         tx_q   <= mem_rdata;
         addr_q <= addr_q + 1'b1;
      end
   end

   ee_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (buf_clr),
      .wr_en    (buf_wr),
      .wr_idx   (addr_q[PAGE_W-1:0]),
      .wr_data  (rx_byte_i),
      .rd_idx   (commit_idx[PAGE_W-1:0]),
      .rd_data  (buf_data),
      .rd_valid (buf_vld)
   );

   ee_wr_timer #(.CYCLES(WR_CYCLES), .CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (commit_start),
      .busy    (busy),
      .elapsed (commit_idx)
   );

   assign mem_we    = busy && (commit_idx < CW'(PAGE_N)) && buf_vld;
   assign mem_waddr = {base_q, commit_idx[PAGE_W-1:0]};

   ee_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (buf_data),
      .raddr (addr_q),
      .rdata (mem_rdata)
   );

   assign ack_o     = ack_q;
   assign tx_byte_o = tx_q;
   assign busy_o    = busy;
endmodule

// File: rtl/ee_cmd_checker.sv
module ee_cmd_checker (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic ack_o,
   input logic rx_valid_i,
   input logic stop_i,
   input logic wp_i,
   input logic mem_we,
   input logic dev_phase
);
   // R1: reset leaves the outputs quiet
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && !ack_o));

   // R2: the acknowledge answer only moves after a received byte
   assert_ack_on_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ack_o) |-> $past(rx_valid_i));

   // R4: the timed cycle is only entered from a stop
   assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));

   // R4: the array is only written inside the timed cycle
   assert_write_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy_o);

   // R5: own control byte refused while the cycle runs
   assert_poll_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rx_valid_i && dev_phase) |=> !ack_o);

   // R10: a protected stop never starts the cycle
   assert_wp_no_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && wp_i && !busy_o) |=> !busy_o);
endmodule

bind eeprom_cmd_engine ee_cmd_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .ack_o      (ack_o),
   .rx_valid_i (rx_valid_i),
   .stop_i     (stop_i),
   .wp_i       (wp_i),
   .mem_we     (mem_we),
   .dev_phase  (dev_phase)
);

// File: tb/tb_eeprom_cmd_engine.sv
module tb_eeprom_cmd_engine;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;
   localparam int PAGE_W     = 5;
   localparam int WR_CYCLES  = 40;
   localparam logic [7:0] DEV_W = 8'hAA;   // 1010_101_0
   localparam logic [7:0] DEV_R = 8'hAB;   // 1010_101_1
   localparam logic [7:0] DEV_X = 8'hA2;   // select 001, foreign

   // {write address, read-back address, data}
   localparam logic [39:0] VEC [6] = '{
      {16'h0100, 16'h0100, 8'h33},
      {16'hFC05, 16'h0005, 8'hC4},
      {16'h0060, 16'h0060, 8'h5A},
      {16'h003F, 16'h003F, 8'h3C},
      {16'h03FF, 16'h03FF, 8'h77},
      {16'h0000, 16'h0000, 8'h11}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] dev_sel_i = 3'b101;
   logic       wp_i = 1'b0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_byte_i = '0;
   logic       tx_req_i = 1'b0;
   logic       ack_o;
   logic [7:0] tx_byte_o;
   logic       busy_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_cmd_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) dut (
      .clk(clk), .rst_n(rst_n), .dev_sel_i(dev_sel_i), .wp_i(wp_i),
      .start_i(start_i), .stop_i(stop_i), .rx_valid_i(rx_valid_i),
      .rx_byte_i(rx_byte_i), .ack_o(ack_o), .tx_req_i(tx_req_i),
      .tx_byte_o(tx_byte_o), .busy_o(busy_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, output logic a);
      rx_byte_i = b; rx_valid_i = 1'b1;
      @(negedge clk);
      rx_valid_i = 1'b0;
      a = ack_o;
   endtask

   task automatic fetch(output logic [7:0] d);
      tx_req_i = 1'b1; @(negedge clk); tx_req_i = 1'b0;
      d = tx_byte_o;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
   endtask

   task automatic byte_write(input logic [15:0] a, input logic [7:0] d);
      logic k0, k1, k2, k3;
      pulse_start();
      send(DEV_W, k0); send(a[15:8], k1); send(a[7:0], k2); send(d, k3);
      check(k0 && k1 && k2 && k3, "R3 write bytes acked", {k0,k1,k2,k3}, 4'hF);
      pulse_stop();
      pulse_start();
      send(DEV_W, k0);
      check(!k0, "R5 poll during cycle", k0, 0);
      wait_idle();
      pulse_start();
      send(DEV_W, k0);
      check(k0, "R5 poll after cycle", k0, 1);
      pulse_stop();
   endtask

   task automatic random_read(input logic [15:0] a, output logic [7:0] d);
      logic k;
      pulse_start();
      send(DEV_W, k); send(a[15:8], k); send(a[7:0], k);
      pulse_start();
      send(DEV_R, k);
      fetch(d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       k;
      logic       all_ack;
      int         n;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy_o && !ack_o && tx_byte_o == 8'h00, "R1 reset outputs",
            {busy_o, ack_o, tx_byte_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !ack_o && tx_byte_o == 8'h00, "R1 after reset",
            {busy_o, ack_o, tx_byte_o}, 0);

      // R3, R8: vector table of byte writes and random read-back
      foreach (VEC[i]) begin
         byte_write(VEC[i][39:24], VEC[i][7:0]);
      end
      foreach (VEC[i]) begin
         random_read(VEC[i][23:8], d);
         check(d == VEC[i][7:0], "R8 random read", d, VEC[i][7:0]);
         pulse_stop();
      end

      // R2: foreign control byte and the byte after it are refused
      pulse_start();
      send(DEV_X, k);
      check(!k, "R2 foreign control byte", k, 0);
      send(8'h00, k);
      check(!k, "R2 byte after refusal", k, 0);
      pulse_stop();

      // R6, R4: 34-byte page write from offset 30 of page 0x40
      pulse_start();
      send(DEV_W, k); all_ack = k;
      send(8'h00, k); all_ack &= k;
      send(8'h5E, k); all_ack &= k;
      for (int j = 0; j < 34; j++) begin
         send(8'hA0 ^ 8'(j), k); all_ack &= k;
      end
      check(all_ack, "R3 page bytes acked", all_ack, 1);
      check(!busy_o, "R4 no cycle before stop", busy_o, 0);
      pulse_stop();
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
      check(n == WR_CYCLES, "R4 cycle length", n, WR_CYCLES);

      // R7: counter wraps inside the page, pointing at offset 0
      pulse_start();
      send(DEV_R, k);
      fetch(d);
      check(d == (8'hA0 ^ 8'd2), "R7 current address read", d, 8'hA0 ^ 8'd2);
      pulse_stop();

      // R6: sequential read of the whole page
      random_read(16'h0040, d);
      for (int o = 0; o < 32; o++) begin
         int j;
         logic [7:0] e;
         j = (o + 2) % 32;
         if (j + 32 <= 33) j = j + 32;
         e = 8'hA0 ^ 8'(j);
         if (o > 0) fetch(d);
         check(d == e, "R6 page contents", d, e);
      end
      pulse_stop();
      random_read(16'h0060, d);
      check(d == 8'h5A, "R6 next page untouched", d, 8'h5A);
      pulse_stop();
      random_read(16'h003F, d);
      check(d == 8'h3C, "R6 previous page untouched", d, 8'h3C);
      pulse_stop();

      // R9: sequential read rolls over the array end
      random_read(16'h03FF, d);
      check(d == 8'h77, "R9 last location", d, 8'h77);
      fetch(d);
      check(d == 8'h11, "R9 rollover to 0", d, 8'h11);
      pulse_stop();

      // R10: protected write is acked but not programmed
      wp_i = 1'b1;
      pulse_start();
      send(DEV_W, k); all_ack = k;
      send(8'h01, k); all_ack &= k;
      send(8'h00, k); all_ack &= k;
      send(8'h99, k); all_ack &= k;
      check(all_ack, "R10 protected bytes acked", all_ack, 1);
      pulse_stop();
      n = 0;
      for (int c = 0; c < 5; c++) begin
         if (busy_o) n++;
         @(negedge clk);
      end
      check(n == 0, "R10 busy stays low", n, 0);
      wp_i = 1'b0;
      random_read(16'h0100, d);
      check(d == 8'h33, "R10 array unchanged", d, 8'h33);
      pulse_stop();

      // R11: stop before data loads the counter only
      pulse_start();
      send(DEV_W, k); send(8'h00, k); send(8'h60, k);
      pulse_stop();
      check(!busy_o, "R11 no cycle", busy_o, 0);
      pulse_start();
      send(DEV_R, k);
      fetch(d);
      check(d == 8'h5A, "R11 counter loaded, data kept", d, 8'h5A);
      pulse_stop();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule